// File: doc/BRIEF.md
# SCSI Host Register Front-End

This block is the byte-wide register interface that a host processor sees on a SCSI bus controller. The host reaches it through a 4-bit register address with separate read and write strobes. One address can lead to different registers depending on direction. Several offsets read back controller state (status, interrupt cause, sequence step, FIFO fill level), while a write to the same offset sets up something else, or nothing at all. The transfer count works the same way. The host writes the low and middle count bytes into hidden shadow registers, and a command byte with its DMA flag set copies those shadows into the readable count.

A write to the command register is decoded into an action. The action takes effect one clock after the write strobe and updates the status, interrupt-cause and sequence-step registers. It can also raise the level interrupt output. The bus itself and the movement of data are abstracted. A DMA transfer command produces a one-cycle start pulse together with a byte length. The surrounding logic returns a one-cycle done pulse when the transfer ends. A small FIFO holds bytes that the host writes and reads through one offset.

Top module: `scsi_host_front`

## Requirements
- R1: After reset, every readable offset returns 0x00 except offset 0xE (count high), which returns the identification value 0x04. The interrupt and start outputs are low.
- R2: Writes at offsets 4–7 do not change what reads at offsets 4–7 return. Writes at offsets 0 and 1 go only to the shadows, and reads there still show the readable count.
- R3: A command byte whose bit 7 is set copies the low and middle shadows into the readable count. With bit 7 clear, the readable count stays as it is. Offset 3 reads back the last accepted command byte.
- R4: Opcode 0x01 (flush) empties the FIFO, so the flags at offset 7 read 0. It also sets the interrupt cause (offset 5) to 0x08 (function complete) and the sequence step (offset 6) to 0.
- R5: Opcode 0x03 (bus reset) sets the interrupt cause to 0x80. It raises the interrupt only when bit 6 of config 1 (offset 8) is clear.
- R6: Opcode 0x02 (chip reset) returns every readable and shadow register to its reset value, empties the FIFO, lowers the interrupt and sets count high to 0x04.
- R7: A host write at offset 0 or 1 clears status bit 4 (terminal count).
- R8: A host read of offset 5 returns the cause value as it stood before the read. It clears status bits 7 (interrupt), 6 (gross error) and 5 (parity error), and it lowers the interrupt output.
- R9: Config 2 (offset 0xB) keeps only the written bits under mask 0x15. Config 1 and offsets 0xC–0xF keep the whole byte, and offset 0xE writes count high directly.
- R10: Opcode 0x10 with bit 7 set clears terminal count and pulses the start output for one cycle. The length output is {mid,low} of the reloaded count, and a count of 0 means 65536. Without bit 7 there is no pulse.
- R11: A done pulse sets status bits 7 and 4 and sets the interrupt cause to 0x10 (bus service). It clears the sequence step, the FIFO, and the readable low and middle counts, and it raises the interrupt.
- R12: A write at offset 2 pushes a byte into the FIFO and a read at offset 2 pops in first-in order. Offset 7 returns the fill count. A write to a full FIFO is dropped, and a read of an empty FIFO returns 0.
- R13: An opcode outside the set 0x00–0x03, 0x10–0x12, 0x1A, 0x42–0x44 changes no register, not even through its DMA flag.
- R14: Opcode 0x11 (command-complete sequence) sets status to 0x93 (interrupt, terminal count, phase 3), cause to 0x18 and sequence step to 4, and raises the interrupt. Opcode 0x12 (message accepted) sets cause to 0x20 (disconnect) and step to 0, and raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (pops the FIFO, acknowledges the interrupt) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data at addr_i |
| irq_o | output | 1 | Level interrupt |
| xfer_start_o | output | 1 | One-cycle DMA transfer start |
| xfer_len_o | output | 17 | Transfer length in bytes, 1..65536 |
| dma_done_i | input | 1 | One-cycle transfer completion |

## Verification
On every cycle the assertions check how the interrupt line and the status flags respond to a done pulse, to an acknowledging read and to writes of the count bytes. They also check the identification value after a chip reset, that unknown opcodes leave the command register unchanged, that the start length stays in range, and that the FIFO count stays bounded. Only the bench scenarios can show the split read and write map, the shadow-to-count reload, the masked config store, FIFO ordering and the full-drop case, and the exact cause and step values each opcode leaves behind.

// File: rtl/scsi_fe_pkg.sv
package scsi_fe_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int LEN_W  = 17;

  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'h0;
  localparam logic [ADDR_W-1:0] A_CNT_MID = 4'h1;
  localparam logic [ADDR_W-1:0] A_FIFO    = 4'h2;
  localparam logic [ADDR_W-1:0] A_CMD     = 4'h3;
  localparam logic [ADDR_W-1:0] A_STAT    = 4'h4;
  localparam logic [ADDR_W-1:0] A_INTR    = 4'h5;
  localparam logic [ADDR_W-1:0] A_SEQ     = 4'h6;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 4'h7;
  localparam logic [ADDR_W-1:0] A_CFG1    = 4'h8;
  localparam logic [ADDR_W-1:0] A_RSV9    = 4'h9;
  localparam logic [ADDR_W-1:0] A_RSVA    = 4'ha;
  localparam logic [ADDR_W-1:0] A_CFG2    = 4'hb;
  localparam logic [ADDR_W-1:0] A_CFG3    = 4'hc;
  localparam logic [ADDR_W-1:0] A_AUXD    = 4'hd;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'he;
  localparam logic [ADDR_W-1:0] A_AUXF    = 4'hf;

  localparam logic [6:0] OP_NOP       = 7'h00;
  localparam logic [6:0] OP_FLUSH     = 7'h01;
  localparam logic [6:0] OP_CHIP_RST  = 7'h02;
  localparam logic [6:0] OP_BUS_RST   = 7'h03;
  localparam logic [6:0] OP_XFER      = 7'h10;
  localparam logic [6:0] OP_CMPL      = 7'h11;
  localparam logic [6:0] OP_MSG_OK    = 7'h12;
  localparam logic [6:0] OP_ATN       = 7'h1a;
  localparam logic [6:0] OP_SEL_ATN   = 7'h42;
  localparam logic [6:0] OP_SEL_STOP  = 7'h43;
  localparam logic [6:0] OP_SEL_EN    = 7'h44;

  localparam int ST_IRQ  = 7;
  localparam int ST_GERR = 6;
  localparam int ST_PERR = 5;
  localparam int ST_TC   = 4;

  localparam logic [DATA_W-1:0] IC_FC   = 8'h08;
  localparam logic [DATA_W-1:0] IC_BS   = 8'h10;
  localparam logic [DATA_W-1:0] IC_DC   = 8'h20;
  localparam logic [DATA_W-1:0] IC_BRST = 8'h80;

  localparam logic [DATA_W-1:0] CFG2_KEEP   = 8'h15;
  localparam logic [DATA_W-1:0] ID_VALUE    = 8'h04;
  localparam logic [DATA_W-1:0] ST_CMPL     = 8'h93;
  localparam logic [DATA_W-1:0] SEQ_CMD_END = 8'h04;
  localparam int CFG1_NO_RST_IRQ = 6;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_IDLE, ACT_FLUSH, ACT_CHIP_RST,
    ACT_BUS_RST, ACT_XFER, ACT_CMPL, ACT_MSG_OK
  } act_e;
endpackage

// File: rtl/scsi_fe_cmd_dec.sv
module scsi_fe_cmd_dec
  import scsi_fe_pkg::*;
(
  input  logic [DATA_W-1:0] cmd_i,
  output act_e              act_o,
  output logic              dma_o
);
  assign dma_o = cmd_i[7];

  always_comb begin
    case (cmd_i[6:0])
      OP_NOP, OP_ATN, OP_SEL_ATN, OP_SEL_STOP, OP_SEL_EN: act_o = ACT_IDLE;
      OP_FLUSH:    act_o = ACT_FLUSH;
      OP_CHIP_RST: act_o = ACT_CHIP_RST;
      OP_BUS_RST:  act_o = ACT_BUS_RST;
      OP_XFER:     act_o = ACT_XFER;
      OP_CMPL:     act_o = ACT_CMPL;
      OP_MSG_OK:   act_o = ACT_MSG_OK;
      default:     act_o = ACT_NONE;
    endcase
  end
endmodule

// File: rtl/scsi_fe_fifo.sv
module scsi_fe_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign rdata_o = mem_q[rp_q];
  assign cnt_o   = cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (do_push && wp_q == PTR_W'(i)) mem_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_q + PTR_W'(do_push);
      rp_q  <= rp_q + PTR_W'(do_pop);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  AST_FIFO_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R12
  AST_FIFO_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !clr_i |=> full_o); // R12
endmodule

// File: rtl/scsi_host_front.sv
module scsi_host_front
  import scsi_fe_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o,
  output logic              xfer_start_o,
  output logic [16:0]       xfer_len_o,
  input  logic              dma_done_i
);
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(1) << (LEN_W - 1);

  // readable registers
  logic [DATA_W-1:0] cnt_lo_q, cnt_lo_d, cnt_mid_q, cnt_mid_d, cnt_hi_q, cnt_hi_d;
  logic [DATA_W-1:0] stat_q, stat_d, intr_q, intr_d, seq_q, seq_d, cmd_q, cmd_d;
  logic [DATA_W-1:0] cfg1_q, cfg1_d, cfg2_q, cfg2_d, cfg3_q, cfg3_d;
  logic [DATA_W-1:0] auxd_q, auxd_d, auxf_q, auxf_d;
  // write-side shadows
  logic [DATA_W-1:0] sh_lo_q, sh_lo_d, sh_mid_q, sh_mid_d;
  logic              irq_q, irq_d, start_q, start_d;
  logic [LEN_W-1:0]  len_q, len_d;

  logic              wr_cmd, cmd_dma, fifo_push, fifo_pop, fifo_clr;
  logic              fifo_full, fifo_empty;
  logic [DATA_W-1:0] fifo_head;
  logic [FCNT_W-1:0] fifo_cnt;
  act_e              act;

  scsi_fe_cmd_dec u_dec (
    .cmd_i (wdata_i),
    .act_o (act),
    .dma_o (cmd_dma)
  );

  assign wr_cmd    = wr_i && (addr_i == A_CMD);
  assign fifo_push = wr_i && (addr_i == A_FIFO);
  assign fifo_pop  = rd_i && (addr_i == A_FIFO);
  assign fifo_clr  = dma_done_i ||
                     (wr_cmd && (act == ACT_FLUSH || act == ACT_CHIP_RST));

  scsi_fe_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fifo_clr),
    .push_i  (fifo_push),
    .pop_i   (fifo_pop),
    .wdata_i (wdata_i),
    .rdata_o (fifo_head),
    .cnt_o   (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  always_comb begin
    cnt_lo_d = cnt_lo_q;  cnt_mid_d = cnt_mid_q; cnt_hi_d = cnt_hi_q;
    stat_d   = stat_q;    intr_d    = intr_q;    seq_d    = seq_q;
    cmd_d    = cmd_q;     cfg1_d    = cfg1_q;    cfg2_d   = cfg2_q;
    cfg3_d   = cfg3_q;    auxd_d    = auxd_q;    auxf_d   = auxf_q;
    sh_lo_d  = sh_lo_q;   sh_mid_d  = sh_mid_q;
    irq_d    = irq_q;     start_d   = 1'b0;      len_d    = len_q;

    if (wr_i) begin
      case (addr_i)
        A_CNT_LO:  begin sh_lo_d  = wdata_i; stat_d[ST_TC] = 1'b0; end
        A_CNT_MID: begin sh_mid_d = wdata_i; stat_d[ST_TC] = 1'b0; end
        A_CMD: begin
          if (act != ACT_NONE) begin
            cmd_d = wdata_i;
            if (cmd_dma) begin
              cnt_lo_d  = sh_lo_q;
              cnt_mid_d = sh_mid_q;
            end
            case (act)
              ACT_FLUSH: begin intr_d = IC_FC; seq_d = '0; end
              ACT_BUS_RST: begin
                intr_d = IC_BRST;
                if (!cfg1_q[CFG1_NO_RST_IRQ]) irq_d = 1'b1;
              end
              ACT_XFER: begin
                if (cmd_dma) begin
                  stat_d[ST_TC] = 1'b0;
                  start_d = 1'b1;
                  len_d = ({sh_mid_q, sh_lo_q} == '0) ? LEN_MAX
                                                      : {1'b0, sh_mid_q, sh_lo_q};
                end
              end
              ACT_CMPL: begin
                stat_d = ST_CMPL; intr_d = IC_FC | IC_BS;
                seq_d  = SEQ_CMD_END; irq_d = 1'b1;
              end
              ACT_MSG_OK: begin intr_d = IC_DC; seq_d = '0; irq_d = 1'b1; end
              ACT_CHIP_RST: begin
                cnt_lo_d = '0; cnt_mid_d = '0; cnt_hi_d = ID_VALUE;
                stat_d   = '0; intr_d    = '0; seq_d    = '0; cmd_d = '0;
                cfg1_d   = '0; cfg2_d    = '0; cfg3_d   = '0;
                auxd_d   = '0; auxf_d    = '0;
                sh_lo_d  = '0; sh_mid_d  = '0; irq_d    = 1'b0;
              end
              default: ;
            endcase
          end
        end
        A_CFG1:   cfg1_d   = wdata_i;
        A_CFG2:   cfg2_d   = wdata_i & CFG2_KEEP;
        A_CFG3:   cfg3_d   = wdata_i;
        A_AUXD:   auxd_d   = wdata_i;
        A_CNT_HI: cnt_hi_d = wdata_i;
        A_AUXF:   auxf_d   = wdata_i;
        default: ; // 4..7, 9, 0xa: write-only settings with no modelled effect
      endcase
    end

    // interrupt acknowledge
    if (rd_i && addr_i == A_INTR) begin
      stat_d[ST_IRQ]  = 1'b0;
      stat_d[ST_GERR] = 1'b0;
      stat_d[ST_PERR] = 1'b0;
      irq_d = 1'b0;
    end

    if (dma_done_i) begin
      stat_d[ST_IRQ] = 1'b1;
      stat_d[ST_TC]  = 1'b1;
      intr_d    = IC_BS;
      seq_d     = '0;
      cnt_lo_d  = '0;
      cnt_mid_d = '0;
      irq_d     = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_lo_q <= '0; cnt_mid_q <= '0; cnt_hi_q <= ID_VALUE;
      stat_q   <= '0; intr_q    <= '0; seq_q    <= '0; cmd_q <= '0;
      cfg1_q   <= '0; cfg2_q    <= '0; cfg3_q   <= '0;
      auxd_q   <= '0; auxf_q    <= '0;
      sh_lo_q  <= '0; sh_mid_q  <= '0;
      irq_q    <= 1'b0; start_q <= 1'b0; len_q <= '0;
    end else begin
      cnt_lo_q <= cnt_lo_d; cnt_mid_q <= cnt_mid_d; cnt_hi_q <= cnt_hi_d;
      stat_q   <= stat_d;   intr_q    <= intr_d;    seq_q    <= seq_d;
      cmd_q    <= cmd_d;    cfg1_q    <= cfg1_d;    cfg2_q   <= cfg2_d;
      cfg3_q   <= cfg3_d;   auxd_q    <= auxd_d;    auxf_q   <= auxf_d;
      sh_lo_q  <= sh_lo_d;  sh_mid_q  <= sh_mid_d;
      irq_q    <= irq_d;    start_q   <= start_d;   len_q    <= len_d;
    end
  end

  always_comb begin
    case (addr_i)
      A_CNT_LO:  rdata_o = cnt_lo_q;
      A_CNT_MID: rdata_o = cnt_mid_q;
      A_FIFO:    rdata_o = fifo_empty ? '0 : fifo_head;
      A_CMD:     rdata_o = cmd_q;
      A_STAT:    rdata_o = stat_q;
      A_INTR:    rdata_o = intr_q;
      A_SEQ:     rdata_o = seq_q;
      A_FLAGS:   rdata_o = DATA_W'(fifo_cnt);
      A_CFG1:    rdata_o = cfg1_q;
      A_CFG2:    rdata_o = cfg2_q;
      A_CFG3:    rdata_o = cfg3_q;
      A_AUXD:    rdata_o = auxd_q;
      A_CNT_HI:  rdata_o = cnt_hi_q;
      A_AUXF:    rdata_o = auxf_q;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o        = irq_q;
  assign xfer_start_o = start_q;
  assign xfer_len_o   = len_q;

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_done_i |=> irq_o && stat_q[ST_IRQ] && stat_q[ST_TC]); // R11
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == A_INTR && !wr_i && !dma_done_i
    |=> !irq_o && stat_q[7:5] == 3'b000); // R8
  AST_COUNT_WRITE_CLEARS_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (addr_i == A_CNT_LO || addr_i == A_CNT_MID) && !dma_done_i
    |=> !stat_q[ST_TC]); // R7
  AST_START_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> xfer_len_o != '0 && xfer_len_o <= LEN_MAX); // R10
  AST_CHIP_RST_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd && wdata_i[6:0] == OP_CHIP_RST && !dma_done_i
    |=> cnt_hi_q == ID_VALUE && !irq_o); // R6
  AST_UNKNOWN_OP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd && act == ACT_NONE |=> $stable(cmd_q) && $stable(cnt_lo_q)); // R13
endmodule

// File: tb/sim_scsi_host_front.sv
module sim_scsi_host_front;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0, dma_done_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        irq_o, xfer_start_o;
  logic [16:0] xfer_len_o;

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  logic [7:0] v;

  always #4 clk_i = ~clk_i;

  scsi_host_front u0 (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i,
    .rdata_o, .irq_o, .xfer_start_o, .xfer_len_o, .dma_done_i
  );

  // {addr, write data, expected read-back}
  localparam logic [19:0] CFG_VEC [12] = '{
    {4'h8, 8'hff, 8'hff}, {4'hb, 8'hff, 8'h15}, {4'hb, 8'hea, 8'h00},
    {4'hc, 8'h5a, 8'h5a}, {4'hd, 8'h33, 8'h33}, {4'hf, 8'hc3, 8'hc3},
    {4'he, 8'h77, 8'h77}, {4'h4, 8'haa, 8'h00}, {4'h6, 8'h55, 8'h00},
    {4'h0, 8'h9c, 8'h00}, {4'h1, 8'h3e, 8'h00}, {4'h8, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk_i);
    dma_done_i = 1'b1;
    @(negedge clk_i);
    dma_done_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL timeout: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1", "irq", irq_o, 0);
    chk("R1", "start", xfer_start_o, 0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk("R1", $sformatf("reg %0h", a), v, (a == 14) ? 8'h04 : 8'h00);
    end

    // R9 / R2 table walk
    for (int i = 0; i < 12; i++) begin
      logic [3:0] a;
      a = CFG_VEC[i][19:16];
      wr(a, CFG_VEC[i][15:8]);
      rd(a, v);
      chk((a < 4'h8) ? "R2" : "R9", $sformatf("vec %0d", i), v, CFG_VEC[i][7:0]);
    end

    // R5 bus reset with and without report disable
    wr(4'h8, 8'h40);
    wr(4'h3, 8'h03);
    chk("R5", "irq masked", irq_o, 0);
    rd(4'h5, v); chk("R5", "cause", v, 8'h80);
    wr(4'h8, 8'h00);
    wr(4'h3, 8'h03);
    chk("R5", "irq raised", irq_o, 1);
    rd(4'h5, v); chk("R8", "cause read", v, 8'h80);
    chk("R8", "irq dropped", irq_o, 0);

    // R2 / R3 shadow reload
    wr(4'h0, 8'h34); wr(4'h1, 8'h12);
    rd(4'h0, v); chk("R2", "count lo before reload", v, 8'h00);
    wr(4'h3, 8'h00);
    rd(4'h0, v); chk("R3", "no reload without dma", v, 8'h00);
    wr(4'h3, 8'h80);
    rd(4'h0, v); chk("R3", "reload lo", v, 8'h34);
    rd(4'h1, v); chk("R3", "reload mid", v, 8'h12);
    rd(4'h3, v); chk("R3", "command readback", v, 8'h80);

    // R11 completion
    wr(4'h2, 8'ha1); wr(4'h2, 8'hb2);
    rd(4'h7, v); chk("R12", "flags 2", v, 8'h02);
    done_pulse();
    chk("R11", "irq", irq_o, 1);
    rd(4'h4, v); chk("R11", "status", v, 8'h90);
    rd(4'h6, v); chk("R11", "seq", v, 8'h00);
    rd(4'h7, v); chk("R11", "flags", v, 8'h00);
    rd(4'h0, v); chk("R11", "count lo", v, 8'h00);
    rd(4'h1, v); chk("R11", "count mid", v, 8'h00);
    rd(4'h5, v); chk("R11", "cause", v, 8'h10);
    rd(4'h4, v); chk("R8", "status after ack", v, 8'h10);
    chk("R8", "irq after ack", irq_o, 0);
    wr(4'h0, 8'h34);
    rd(4'h4, v); chk("R7", "tc cleared", v, 8'h00);

    // R10 transfer
    done_pulse();
    rd(4'h5, v);
    wr(4'h3, 8'h90);
    chk("R10", "start pulse", xfer_start_o, 1);
    chk("R10", "length", xfer_len_o, 17'h01234);
    @(negedge clk_i);
    chk("R10", "pulse one cycle", xfer_start_o, 0);
    rd(4'h4, v); chk("R10", "tc cleared", v, 8'h00);
    rd(4'h0, v); chk("R3", "reloaded lo", v, 8'h34);
    wr(4'h0, 8'h00); wr(4'h1, 8'h00);
    wr(4'h3, 8'h90);
    chk("R10", "start zero count", xfer_start_o, 1);
    chk("R10", "length 65536", xfer_len_o, 17'h10000);
    wr(4'h3, 8'h10);
    chk("R10", "no start without dma", xfer_start_o, 0);

    // R14 command-complete and message accepted
    wr(4'h3, 8'h11);
    chk("R14", "cmpl irq", irq_o, 1);
    rd(4'h4, v); chk("R14", "cmpl status", v, 8'h93);
    rd(4'h6, v); chk("R14", "cmpl seq", v, 8'h04);
    rd(4'h5, v); chk("R14", "cmpl cause", v, 8'h18);
    wr(4'h3, 8'h12);
    chk("R14", "msg irq", irq_o, 1);
    rd(4'h6, v); chk("R14", "msg seq", v, 8'h00);
    rd(4'h5, v); chk("R14", "msg cause", v, 8'h20);
    wr(4'h3, 8'h11);
    rd(4'h5, v);

    // R12 FIFO order and full drop, R4 flush
    wr(4'h2, 8'h11); wr(4'h2, 8'h22); wr(4'h2, 8'h33);
    rd(4'h7, v); chk("R12", "flags 3", v, 8'h03);
    rd(4'h2, v); chk("R12", "pop 1", v, 8'h11);
    rd(4'h2, v); chk("R12", "pop 2", v, 8'h22);
    rd(4'h7, v); chk("R12", "flags 1", v, 8'h01);
    wr(4'h2, 8'h44); wr(4'h2, 8'h55); wr(4'h2, 8'h66); wr(4'h2, 8'h77);
    rd(4'h7, v); chk("R12", "flags full", v, 8'h04);
    rd(4'h2, v); chk("R12", "pop 3", v, 8'h33);
    rd(4'h2, v); chk("R12", "pop after drop", v, 8'h44);
    wr(4'h3, 8'h01);
    rd(4'h7, v); chk("R4", "flags flushed", v, 8'h00);
    rd(4'h5, v); chk("R4", "cause", v, 8'h08);
    rd(4'h6, v); chk("R4", "seq", v, 8'h00);
    rd(4'h2, v); chk("R12", "empty read", v, 8'h00);

    // R13 unknown opcode
    wr(4'h0, 8'h66);
    wr(4'h3, 8'hd5);
    rd(4'h3, v); chk("R13", "command kept", v, 8'h01);
    rd(4'h0, v); chk("R13", "no reload", v, 8'h00);
    rd(4'h5, v); chk("R13", "cause kept", v, 8'h08);
    chk("R13", "irq", irq_o, 0);

    // R6 chip reset
    wr(4'he, 8'h99); wr(4'h8, 8'ha5); wr(4'h2, 8'h5e);
    wr(4'h3, 8'h03);
    chk("R6", "irq before", irq_o, 1);
    wr(4'h3, 8'h02);
    chk("R6", "irq cleared", irq_o, 0);
    rd(4'he, v); chk("R6", "id value", v, 8'h04);
    rd(4'h8, v); chk("R6", "cfg1", v, 8'h00);
    rd(4'h3, v); chk("R6", "command", v, 8'h00);
    rd(4'h7, v); chk("R6", "fifo", v, 8'h00);
    wr(4'h3, 8'h80);
    rd(4'h0, v); chk("R6", "shadow cleared", v, 8'h00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule